// File: doc/BRIEF.md
# Master Clock Source Switch Controller

This block selects the master clock from five candidates: a fast internal RC, the main crystal oscillator, the PLL, a slow internal RC and the sub (low-frequency) oscillator. Software writes one control byte. That byte holds the requested source code and enable bits for the main, sub and PLL oscillators. The block drives the oscillator enable outputs and runs a stabilization counter for each of the three external-type oscillators. It reports a status byte that holds the source that is actually current and the three ready flags.

A change of source is never taken at once. The request is held in a small state machine until the requested source is stable, and only then is the current-source field updated. While both the current and the requested source are slow ones (slow RC or sub), the fast RC, main and PLL oscillators are held off, whatever their enable bits say.

The state machine has two states. ST_RUN is the state where the current source matches the request. ST_WAIT is the state where a different source has been requested and the block is waiting for it. The transitions are:
- ST_RUN→ST_WAIT when the request differs from the current source.
- ST_WAIT→ST_RUN with commit when the target is ready.
- ST_WAIT→ST_RUN with cancel when the request returns to the current source.

The registers are cleared only by the hardware reset `rst_ni`.

Top module: `mclk_switch`

## Requirements
- R1: After reset the control byte reads 0x00, the status byte reads 0x00 (fast RC current, no oscillator ready), and only the fast RC enable (`osc_en_o[3]`) is high.
- R2: Source codes are 000 fast RC, 001 main, 010 PLL, 100 slow RC and 101 sub. In the control byte, bits 7:5 hold the request, bit 4 the PLL enable, bit 3 the sub enable and bit 1 the main enable. Bits 2 and 0 always read 0. A write shows in `ctrl_o` one cycle after the write edge.
- R3: A write whose bits 7:5 carry 011, 110 or 111 is dropped entirely, and the control byte keeps its previous value.
- R4: In the status byte, bits 7:5 hold the current source, bit 4 PLL ready, bit 3 sub ready and bit 1 main ready, with the other bits 0. The current field takes the requested code only once the target is ready. From ST_RUN with an already-ready target, it changes on the second edge after the write edge.
- R5: Each oscillator's counter loads its wait value while its enable output is low. It counts down once per edge while the enable output and its alive input are high. The ready bit is set on the edge after the count reaches zero, which is load+1 counting edges after the enable rises. Counting pauses while alive is low.
- R6: A ready bit clears on the edge after its enable output falls.
- R7: While both the current and the requested source are slow RC or sub, `osc_en_o[0]` (main), `osc_en_o[2]` (PLL) and `osc_en_o[3]` (fast RC) are 0. They return as soon as the request leaves the slow group, with the enable bits intact. `osc_en_o[1]` (sub) follows its enable bit.
- R8: A write cannot clear the enable bit of the source that is currently active; that bit reads back as 1.
- R9: In ST_WAIT, a new request is taken as the new target, and it commits on the first edge where that target is ready. A request equal to the current source cancels the wait without changing the current field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hardware reset, active low, asynchronous |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte write data |
| wait_main_i | input | WAIT_W | Main oscillator stabilization count |
| wait_sub_i | input | WAIT_W | Sub oscillator stabilization count |
| wait_pll_i | input | WAIT_W | PLL stabilization count |
| osc_alive_i | input | 3 | Oscillator running indication: [0] main, [1] sub, [2] PLL |
| ctrl_o | output | 8 | Control byte read value |
| stat_o | output | 8 | Status byte read value |
| osc_en_o | output | 4 | Oscillator enables: [0] main, [1] sub, [2] PLL, [3] fast RC |

## Verification
The bench targets several corner cases:
- Switching to a source whose oscillator is still counting. A design that commits early would show the new current code while the ready bit is still 0.
- A counter held by a low alive input. An off-by-one there would set ready one edge early or late.
- Entering slow RC from main with PLL enabled. A design missing the slow gate would leave `osc_en_o` high in slow mode.
- A design without the guard would let software clear the main enable while main is current.
- Retargeting and cancelling inside ST_WAIT. A design that latched the first target would commit to a PLL that never becomes ready.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    typedef enum logic [2:0] {
        SRC_HSRC = 3'b000,
        SRC_MAIN = 3'b001,
        SRC_PLL  = 3'b010,
        SRC_LSRC = 3'b100,
        SRC_SUB  = 3'b101
    } src_e;

    typedef enum logic {
        ST_RUN,
        ST_WAIT
    } sw_state_e;

    localparam int unsigned N_OSC   = 3;
    localparam int unsigned OSC_MAIN = 0;
    localparam int unsigned OSC_SUB  = 1;
    localparam int unsigned OSC_PLL  = 2;

    // bits of the control byte that software may set
    localparam logic [7:0] CTRL_MASK = 8'b1111_1010;

    function automatic logic code_legal(input logic [2:0] c);
        return (c == 3'b000) || (c == 3'b001) || (c == 3'b010) ||
               (c == 3'b100) || (c == 3'b101);
    endfunction

    function automatic logic code_slow(input logic [2:0] c);
        return (c == 3'b100) || (c == 3'b101);
    endfunction

endpackage

// File: rtl/mcs_stab_cnt.sv
module mcs_stab_cnt #(
    parameter int unsigned WAIT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              alive_i,
    input  logic [WAIT_W-1:0] load_i,
    output logic              rdy_o
);

    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            rdy_o <= 1'b0;
        end else if (!run_i) begin
            cnt_q <= load_i;
            rdy_o <= 1'b0;
        end else if (alive_i) begin
            if (cnt_q == '0) begin
                rdy_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/mcs_fsm.sv
module mcs_fsm
    import mcs_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] req_i,
    input  logic       tgt_rdy_i,
    output logic [2:0] cur_o
);

    sw_state_e state_q, state_d;
    logic [2:0] cur_q, cur_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_RUN;
            cur_q   <= SRC_HSRC;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    // next state and commit
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        unique case (state_q)
            ST_RUN: begin
                if (req_i != cur_q) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (req_i == cur_q) begin
                    state_d = ST_RUN;
                end else if (tgt_rdy_i) begin
                    cur_d   = req_i;
                    state_d = ST_RUN;
                end
            end
        endcase
    end

    assign cur_o = cur_q;

endmodule

// File: rtl/mclk_switch.sv
module mclk_switch
    import mcs_pkg::*;
#(
    parameter int unsigned WAIT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_data_i,
    input  logic [WAIT_W-1:0] wait_main_i,
    input  logic [WAIT_W-1:0] wait_sub_i,
    input  logic [WAIT_W-1:0] wait_pll_i,
    input  logic [2:0]        osc_alive_i,
    output logic [7:0]        ctrl_o,
    output logic [7:0]        stat_o,
    output logic [3:0]        osc_en_o
);

    logic [7:0]        ctrl_q;
    logic [2:0]        cur;
    logic [2:0]        req;
    logic [N_OSC-1:0]  en_bit;
    logic [N_OSC-1:0]  osc_run;
    logic [N_OSC-1:0]  osc_rdy;
    logic [WAIT_W-1:0] load_val [N_OSC];
    logic              fast_ok;
    logic              hsrc_on;
    logic              tgt_rdy;
    logic [7:0]        hold_bits;

    assign req                = ctrl_q[7:5];
    assign en_bit[OSC_MAIN]   = ctrl_q[1];
    assign en_bit[OSC_SUB]    = ctrl_q[3];
    assign en_bit[OSC_PLL]    = ctrl_q[4];

    // enable of the active source cannot be dropped by a write
    always_comb begin
        hold_bits    = 8'h00;
        hold_bits[1] = (cur == SRC_MAIN);
        hold_bits[3] = (cur == SRC_SUB);
        hold_bits[4] = (cur == SRC_PLL);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= 8'h00;
        end else if (wr_en_i && code_legal(wr_data_i[7:5])) begin
            ctrl_q <= (wr_data_i & CTRL_MASK) | hold_bits;
        end
    end

    // fast sources stay stopped while running slow and asked for slow
    assign fast_ok = !(code_slow(cur) && code_slow(req));
    assign hsrc_on = fast_ok;

    assign osc_run[OSC_MAIN] = en_bit[OSC_MAIN] && fast_ok;
    assign osc_run[OSC_SUB]  = en_bit[OSC_SUB];
    assign osc_run[OSC_PLL]  = en_bit[OSC_PLL] && fast_ok;

    assign load_val[OSC_MAIN] = wait_main_i;
    assign load_val[OSC_SUB]  = wait_sub_i;
    assign load_val[OSC_PLL]  = wait_pll_i;

    for (genvar g = 0; g < N_OSC; g++) begin : g_stab
        mcs_stab_cnt #(.WAIT_W(WAIT_W)) u_cnt (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .run_i   (osc_run[g]),
            .alive_i (osc_alive_i[g]),
            .load_i  (load_val[g]),
            .rdy_o   (osc_rdy[g])
        );
    end

    always_comb begin
        unique case (req)
            3'b000:  tgt_rdy = hsrc_on;
            3'b001:  tgt_rdy = osc_rdy[OSC_MAIN];
            3'b010:  tgt_rdy = osc_rdy[OSC_PLL];
            3'b100:  tgt_rdy = 1'b1;
            3'b101:  tgt_rdy = osc_rdy[OSC_SUB];
            default: tgt_rdy = 1'b0;
        endcase
    end

    mcs_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .req_i     (req),
        .tgt_rdy_i (tgt_rdy),
        .cur_o     (cur)
    );

    assign ctrl_o   = ctrl_q;
    assign stat_o   = {cur, osc_rdy[OSC_PLL], osc_rdy[OSC_SUB], 1'b0,
                       osc_rdy[OSC_MAIN], 1'b0};
    assign osc_en_o = {hsrc_on, osc_run[OSC_PLL], osc_run[OSC_SUB],
                       osc_run[OSC_MAIN]};

endmodule

// File: rtl/mclk_switch_chk.sv
module mclk_switch_chk
    import mcs_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wr_en_i,
    input logic [2:0] wr_code_i,
    input logic [7:0] ctrl_i,
    input logic [2:0] cur_i,
    input logic [2:0] rdy_i,
    input logic [3:0] en_i
);

    // R4
    legal_cur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        code_legal(cur_i));

    // R4
    commit_main_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_i == 3'b001 && $past(cur_i) != 3'b001) |-> $past(rdy_i[0]));

    // R4
    commit_pll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_i == 3'b010 && $past(cur_i) != 3'b010) |-> $past(rdy_i[2]));

    // R4
    commit_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_i == 3'b101 && $past(cur_i) != 3'b101) |-> $past(rdy_i[1]));

    // R7
    slow_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (code_slow(cur_i) && code_slow(ctrl_i[7:5])) |-> (en_i[0] == 1'b0 && en_i[2] == 1'b0 && en_i[3] == 1'b0));

    // R6
    main_rdy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(en_i[0]) |=> !rdy_i[0]);

    // R6
    sub_rdy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(en_i[1]) |=> !rdy_i[1]);

    // R8
    hold_main_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_i == 3'b001) |-> ctrl_i[1]);

    // R8
    hold_pll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_i == 3'b010) |-> ctrl_i[4]);

    // R3
    bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !code_legal(wr_code_i)) |=> $stable(ctrl_i));

endmodule

bind mclk_switch mclk_switch_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_code_i (wr_data_i[7:5]),
    .ctrl_i    (ctrl_o),
    .cur_i     (stat_o[7:5]),
    .rdy_i     ({stat_o[4], stat_o[3], stat_o[1]}),
    .en_i      (osc_en_o)
);

// File: tb/tb_mclk_switch.sv
module tb_mclk_switch;

    localparam int W  = 8;
    localparam int LM = 5;
    localparam int LS = 7;
    localparam int LP = 4;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         wr_en_i = 1'b0;
    logic [7:0]   wr_data_i = 8'h00;
    logic [W-1:0] wait_main_i = W'(LM);
    logic [W-1:0] wait_sub_i  = W'(LS);
    logic [W-1:0] wait_pll_i  = W'(LP);
    logic [2:0]   osc_alive_i = 3'b111;
    logic [7:0]   ctrl_o, stat_o;
    logic [3:0]   osc_en_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk_i = ~clk_i;   // 250 MHz

    mclk_switch #(.WAIT_W(W)) dut (
        .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .wait_main_i, .wait_sub_i,
        .wait_pll_i, .osc_alive_i, .ctrl_o, .stat_o, .osc_en_o
    );

    // ---------------- behavioural reference ----------------
    int m_sel, m_cur;
    bit m_men, m_sen, m_pen, m_wait;
    int m_cnt [3];
    bit m_rdy [3];

    function automatic bit slow(int c); return c == 4 || c == 5; endfunction
    function automatic bit legal(int c); return c == 0 || c == 1 || c == 2 || c == 4 || c == 5; endfunction

    function automatic bit [3:0] m_en();
        bit f;
        f = !(slow(m_cur) && slow(m_sel));
        return {f, m_pen && f, m_sen, m_men && f};
    endfunction

    always @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_sel = 0; m_cur = 0; m_men = 0; m_sen = 0; m_pen = 0; m_wait = 0;
            for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_rdy[i] = 0; end
        end else begin
            bit [3:0] en;
            bit trdy;
            int loads [3];
            int n_sel, n_cur;
            bit n_wait;
            en = m_en();
            loads[0] = LM; loads[1] = LS; loads[2] = LP;
            case (m_sel)
                0: trdy = en[3];
                1: trdy = m_rdy[0];
                2: trdy = m_rdy[2];
                4: trdy = 1;
                5: trdy = m_rdy[1];
                default: trdy = 0;
            endcase
            n_cur = m_cur; n_wait = m_wait; n_sel = m_sel;
            if (!m_wait) begin
                if (m_sel != m_cur) n_wait = 1;
            end else if (m_sel == m_cur) begin
                n_wait = 0;
            end else if (trdy) begin
                n_cur = m_sel; n_wait = 0;
            end
            for (int i = 0; i < 3; i++) begin
                if (!en[i]) begin
                    m_cnt[i] = loads[i]; m_rdy[i] = 0;
                end else if (osc_alive_i[i]) begin
                    if (m_cnt[i] == 0) m_rdy[i] = 1;
                    else m_cnt[i] = m_cnt[i] - 1;
                end
            end
            if (wr_en_i && legal(int'(wr_data_i[7:5]))) begin
                n_sel = int'(wr_data_i[7:5]);
                m_pen = wr_data_i[4] || (m_cur == 2);
                m_sen = wr_data_i[3] || (m_cur == 5);
                m_men = wr_data_i[1] || (m_cur == 1);
            end
            m_sel = n_sel; m_cur = n_cur; m_wait = n_wait;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk_i) begin
        if (rst_ni && !done) begin
            chk("R2 ctrl vs model", ctrl_o,
                {m_sel[2:0], m_pen, m_sen, 1'b0, m_men, 1'b0});
            chk("R4 stat vs model", stat_o,
                {m_cur[2:0], m_rdy[2], m_rdy[1], 1'b0, m_rdy[0], 1'b0});
            chk("R7 osc_en vs model", {4'h0, osc_en_o}, {4'h0, m_en()});
        end
    end

    task automatic wr(input logic [7:0] d);
        wr_en_i = 1'b1; wr_data_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk_i);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(3);
        rst_ni = 1'b1;
        step(1);
        // R1
        chk("R1 ctrl reset", ctrl_o, 8'h00);
        chk("R1 stat reset", stat_o, 8'h00);
        chk("R1 osc_en reset", {4'h0, osc_en_o}, 8'h08);

        // R2 reserved bits ignored
        wr(8'h05);
        chk("R2 reserved read 0", ctrl_o, 8'h00);
        wr(8'h02);
        chk("R2 main enable", ctrl_o, 8'h02);
        chk("R2 main osc on", {4'h0, osc_en_o}, 8'h09);
        // R5 main counter
        step(5);
        chk("R5 main not yet ready", stat_o, 8'h00);
        step(1);
        chk("R5 main ready", stat_o, 8'h02);

        // R5 pause while alive low
        osc_alive_i[1] = 1'b0;
        wr(8'h0A);
        step(20);
        chk("R5 sub paused", stat_o, 8'h02);
        osc_alive_i[1] = 1'b1;
        step(7);
        chk("R5 sub one short", stat_o, 8'h02);
        step(1);
        chk("R5 sub ready", stat_o, 8'h0A);

        // R4 commit to main
        wr(8'h2A);
        chk("R4 no commit yet", stat_o, 8'h0A);
        step(1);
        chk("R4 waiting", stat_o, 8'h0A);
        step(1);
        chk("R4 main committed", stat_o, 8'h2A);

        // R8 + R6
        wr(8'h20);
        chk("R8 main en held", ctrl_o, 8'h22);
        chk("R6 sub osc off", {4'h0, osc_en_o}, 8'h09);
        chk("R6 sub rdy lingers one cycle", stat_o, 8'h2A);
        step(1);
        chk("R6 sub rdy cleared", stat_o, 8'h22);

        // R3
        wr(8'h62);
        chk("R3 code 011 dropped", ctrl_o, 8'h22);
        wr(8'hDE);
        chk("R3 code 110 dropped", ctrl_o, 8'h22);
        wr(8'hE0);
        chk("R3 code 111 dropped", ctrl_o, 8'h22);

        // R7 enter slow RC with PLL and main enabled
        wr(8'h92);
        chk("R7 ctrl", ctrl_o, 8'h92);
        chk("R7 fast on before commit", {4'h0, osc_en_o}, 8'h0D);
        step(1);
        chk("R7 still main", stat_o, 8'h22);
        step(1);
        chk("R7 slow committed", stat_o, 8'h82);
        chk("R7 fast gated", {4'h0, osc_en_o}, 8'h00);
        step(1);
        chk("R7 main rdy dropped", stat_o, 8'h80);
        chk("R7 enables kept", ctrl_o, 8'h92);

        // R7 leave slow group
        wr(8'h12);
        chk("R7 fast restart", {4'h0, osc_en_o}, 8'h0D);
        step(2);
        chk("R4 fast RC committed", stat_o, 8'h00);

        // R9 retarget
        osc_alive_i[2] = 1'b0;
        step(8);
        chk("R5 main ready again", stat_o, 8'h02);
        wr(8'h52);
        step(10);
        chk("R9 PLL never ready, held", stat_o, 8'h02);
        wr(8'h32);
        chk("R9 retarget pending", stat_o, 8'h02);
        step(1);
        chk("R9 retarget committed", stat_o, 8'h22);
        // R9 cancel
        wr(8'h52);
        wr(8'h32);
        step(3);
        chk("R9 cancel keeps main", stat_o, 8'h22);

        osc_alive_i = 3'b111;
        step(10);
        chk("R5 pll ready", stat_o, 8'h32);

        // sub mode
        wr(8'hBA);
        step(12);
        chk("R4 sub committed", stat_o, 8'hA8);
        chk("R7 sub mode gating", {4'h0, osc_en_o}, 8'h02);
        wr(8'hB2);
        chk("R8 sub en held", ctrl_o, 8'hBA);
        step(2);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule